// File: doc/BRIEF.md
# Linked Descriptor Chain Walker

This block runs the descriptor side of a scatter-gather transfer engine. Software places transfer descriptors in memory, links them through next pointers, and programs two pointers: where the walk begins and which descriptor is the last one. The walker then reads each descriptor over a word-wide memory port. It hands the buffer address, byte count, packet-boundary flags and channel tags to a data mover as one command. When the mover reports how many bytes it moved, the walker writes a completion word back into that descriptor and goes on to the next one.

Each descriptor occupies a 64-byte slot. The walker reads four of its 32-bit words: the next pointer at byte offset 0, the buffer address at 4, the control word at 16 and the tag word at 24. It writes the status word at offset 20. Software controls the walker through a three-entry write port that holds the run bit, the current pointer and the tail pointer. The walker reports progress through a halted flag, an idle flag, an error flag and the live current pointer.

Top module: `sgw_walker`

## Requirements
- R1: A walk begins only when the run bit (select 0, bit 0) is 1 and the tail pointer (select 2) has been written since the last walk began, in either order. The first descriptor read is at the current pointer (select 1).
- R2: Each descriptor produces exactly one command. Its address is word 1 of the descriptor. Its length is bits 22:0 of word 4, and its start-of-packet and end-of-packet flags are bits 27 and 26 of word 4.
- R3: The command carries a stream ID taken from bits 4:0 of word 6 and a destination tag taken from bits 12:8 of word 6.
- R4: After the mover reports completion, the walker writes word 5 of the descriptor as bit 31 = 1, bits 30:23 = 0, and bits 22:0 = the byte count the mover reported.
- R5: Once a descriptor's status is written, the walker fetches the descriptor that its word 0 points to. It stops after completing the descriptor whose address equals the tail pointer. At that point the current pointer holds that descriptor's next pointer and idle is 1.
- R6: Writing the tail pointer while the walker is running and idle restarts the walk from the current pointer.
- R7: Clearing the run bit lets the descriptor in progress finish, including its status write. After that the walker reads no more descriptors and asserts halted.
- R8: A descriptor pointer with any of bits 5:0 set raises err and halted, whether the pointer comes from software or from a chain link. The walker issues no read or command for that pointer, and err stays set until reset.
- R9: Writes to the current pointer are ignored unless the walker is halted.
- R10: After reset, halted = 1, idle = 0, err = 0, there is no memory request and no command, and the current pointer is 0.
- R11: A command stays valid with unchanged fields until the mover accepts it, and no descriptor is issued twice while the mover stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 run, 1 current pointer, 2 tail pointer |
| reg_wdata | input | 32 | Register write data |
| cur_ptr | output | 32 | Current descriptor pointer |
| halted | output | 1 | Walker stopped |
| idle | output | 1 | Running with no descriptor in progress |
| err | output | 1 | Misaligned descriptor pointer seen |
| mem_req | output | 1 | Descriptor memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Request completed |
| cmd_valid | output | 1 | Transfer command valid |
| cmd_ready | input | 1 | Mover accepts command |
| cmd_addr | output | 32 | Buffer address |
| cmd_len | output | 23 | Byte length |
| cmd_sof | output | 1 | Start of packet |
| cmd_eof | output | 1 | End of packet |
| cmd_tid | output | 5 | Stream ID |
| cmd_tdest | output | 5 | Destination tag |
| sts_valid | input | 1 | Mover completion pulse |
| sts_bytes | input | 23 | Bytes the mover transferred |

## Verification
The bench builds chains of one to four descriptors and alternates whether run or the tail write comes last. A walker that stops one descriptor early or late shows up as a wrong command count and as a status word missing in the last slot or written into the next one. The mover reports one byte fewer than requested, so a design that writes back the programmed length instead of the reported count fails the status check. The mover's ready signal toggles, which catches commands that are dropped or issued twice during a stall. Further cases cover a stop request while a transfer is in flight (a wrong design aborts the write-back or keeps reading the chain), a tail rewrite on an idle walker (a wrong design ignores it or restarts at the old head), current-pointer writes while running, and misaligned pointers from software and from a chain link (a wrong design fetches from them).

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int ADDR_W    = 32;
  localparam int WORD_W    = 32;
  localparam int LEN_W     = 23;
  localparam int TAG_W     = 5;
  localparam int ALIGN_LSB = 6;            // 64-byte descriptor slots
  localparam int SOF_BIT   = 27;
  localparam int EOF_BIT   = 26;
  localparam int TDEST_LSB = 8;
  localparam int NFETCH    = 4;            // words read per descriptor
  localparam logic [ALIGN_LSB-1:0] STATUS_OFS = 6'd20;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_ISSUE, ST_WAIT, ST_WBACK
  } walk_st_e;

  // byte offset of the k-th fetched word: next, buffer, control, tag
  function automatic logic [ALIGN_LSB-1:0] fetch_offset(input logic [1:0] k);
    case (k)
      2'd0:    return 6'd0;
      2'd1:    return 6'd4;
      2'd2:    return 6'd16;
      default: return 6'd24;
    endcase
  endfunction

  function automatic logic ptr_aligned(input logic [ADDR_W-1:0] p);
    return p[ALIGN_LSB-1:0] == '0;
  endfunction

  function automatic logic [WORD_W-1:0] status_word(input logic [LEN_W-1:0] bytes);
    return {1'b1, {(WORD_W-LEN_W-1){1'b0}}, bytes};
  endfunction
endpackage

// File: rtl/sgw_regs.sv
module sgw_regs
  import sgw_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [31:0]   wr_data,
  input  logic          pend_clr,
  output logic          run,
  output logic [AW-1:0] tail_ptr,
  output logic          tail_pend,
  output logic          cur_wr,
  output logic [AW-1:0] cur_wdata
);
  logic tail_wr;
  assign tail_wr   = wr_en && (wr_sel == 2'd2);
  assign cur_wr    = wr_en && (wr_sel == 2'd1);
  assign cur_wdata = wr_data[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run       <= 1'b0;
      tail_ptr  <= '0;
      tail_pend <= 1'b0;
    end else begin
      if (wr_en && wr_sel == 2'd0) run <= wr_data[0];
      if (tail_wr) tail_ptr <= wr_data[AW-1:0];
      if (tail_wr)       tail_pend <= 1'b1;   // a new tail wins over a same-cycle start
      else if (pend_clr) tail_pend <= 1'b0;
    end
  end

  AST_PEND_ON_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    tail_wr |=> tail_pend) else $error("tail write lost"); // R1
endmodule

// File: rtl/sgw_desc_capture.sv
module sgw_desc_capture
  import sgw_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int LW = LEN_W,
  parameter int TW = TAG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [1:0]    cap_idx,
  input  logic [31:0]   word,
  output logic [AW-1:0] next_ptr,
  output logic [AW-1:0] buf_addr,
  output logic [LW-1:0] len,
  output logic          sof,
  output logic          eof,
  output logic [TW-1:0] tid,
  output logic [TW-1:0] tdest
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_ptr <= '0; buf_addr <= '0; len <= '0;
      sof <= 1'b0; eof <= 1'b0; tid <= '0; tdest <= '0;
    end else if (cap_en) begin
      case (cap_idx)
        2'd0: next_ptr <= word[AW-1:0];
        2'd1: buf_addr <= word[AW-1:0];
        2'd2: begin
          len <= word[LW-1:0];
          sof <= word[SOF_BIT];
          eof <= word[EOF_BIT];
        end
        default: begin
          tid   <= word[TW-1:0];
          tdest <= word[TDEST_LSB +: TW];
        end
      endcase
    end
  end
endmodule

// File: rtl/sgw_engine.sv
module sgw_engine
  import sgw_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int LW = LEN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [AW-1:0] tail_ptr,
  input  logic          tail_pend,
  output logic          pend_clr,
  input  logic          cur_wr,
  input  logic [AW-1:0] cur_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  output logic          cap_en,
  output logic [1:0]    cap_idx,
  input  logic [AW-1:0] next_ptr,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  input  logic          sts_valid,
  input  logic [LW-1:0] sts_bytes,
  output logic [AW-1:0] cur_ptr,
  output logic          halted,
  output logic          idle,
  output logic          err
);
  walk_st_e      st;
  logic [1:0]    k;
  logic [LW-1:0] wb_bytes;

  // named internal events
  logic cur_take, walk_start, desc_done, at_tail;
  assign cur_take   = cur_wr && halted && (st == ST_IDLE);
  assign walk_start = (st == ST_IDLE) && !err && run && tail_pend && !cur_take;
  assign desc_done  = (st == ST_WBACK) && mem_ack;
  assign at_tail    = (cur_ptr == tail_ptr);
  assign pend_clr   = walk_start;

  assign mem_req   = (st == ST_FETCH) || (st == ST_WBACK);
  assign mem_we    = (st == ST_WBACK);
  assign mem_addr  = cur_ptr + AW'((st == ST_FETCH) ? fetch_offset(k) : STATUS_OFS);
  assign mem_wdata = status_word(wb_bytes);
  assign cap_en    = (st == ST_FETCH) && mem_ack;
  assign cap_idx   = k;
  assign cmd_valid = (st == ST_ISSUE);
  assign idle      = (st == ST_IDLE) && !halted && !err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; k <= '0; cur_ptr <= '0;
      halted <= 1'b1; err <= 1'b0; wb_bytes <= '0;
    end else begin
      if (cur_take) cur_ptr <= cur_wdata;
      case (st)
        ST_IDLE: begin
          if (err || !run) halted <= 1'b1;
          else begin
            halted <= 1'b0;
            if (walk_start) begin
              if (!ptr_aligned(cur_ptr)) begin
                err <= 1'b1; halted <= 1'b1;
              end else begin
                st <= ST_FETCH; k <= '0;
              end
            end
          end
        end
        ST_FETCH: if (mem_ack) begin
          if (k == 2'(NFETCH-1)) st <= ST_ISSUE;
          else k <= k + 2'd1;
        end
        ST_ISSUE: if (cmd_ready) st <= ST_WAIT;
        ST_WAIT: if (sts_valid) begin
          wb_bytes <= sts_bytes;
          st       <= ST_WBACK;
        end
        ST_WBACK: if (mem_ack) begin
          cur_ptr <= next_ptr;
          if (at_tail || !run) st <= ST_IDLE;
          else if (!ptr_aligned(next_ptr)) begin
            err <= 1'b1; halted <= 1'b1; st <= ST_IDLE;
          end else begin
            st <= ST_FETCH; k <= '0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_TAIL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    desc_done && at_tail |=> st == ST_IDLE) else $error("walk past tail"); // R5
  AST_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ptr_aligned(cur_ptr)) else $error("misaligned access"); // R8
  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> halted) else $error("error without halt"); // R8
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_req && !cmd_valid) else $error("traffic while halted"); // R7
  AST_CUR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !halted && !desc_done |=> $stable(cur_ptr)) else $error("pointer moved"); // R9
  AST_WB_AFTER_STS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT) && sts_valid |=> mem_req && mem_we) else $error("no write-back"); // R4
endmodule

// File: rtl/sgw_walker.sv
module sgw_walker
  import sgw_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int LW = LEN_W,
  parameter int TW = TAG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic [AW-1:0] cur_ptr,
  output logic          halted,
  output logic          idle,
  output logic          err,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [AW-1:0] cmd_addr,
  output logic [LW-1:0] cmd_len,
  output logic          cmd_sof,
  output logic          cmd_eof,
  output logic [TW-1:0] cmd_tid,
  output logic [TW-1:0] cmd_tdest,
  input  logic          sts_valid,
  input  logic [LW-1:0] sts_bytes
);
  logic          run, tail_pend, pend_clr, cur_wr, cap_en;
  logic [AW-1:0] tail_ptr, cur_wdata, next_ptr;
  logic [1:0]    cap_idx;

  sgw_regs #(.AW(AW)) u_regs (
    .clk, .rst_n, .wr_en(reg_we), .wr_sel(reg_sel), .wr_data(reg_wdata),
    .pend_clr, .run, .tail_ptr, .tail_pend, .cur_wr, .cur_wdata
  );

  sgw_desc_capture #(.AW(AW), .LW(LW), .TW(TW)) u_cap (
    .clk, .rst_n, .cap_en, .cap_idx, .word(mem_rdata),
    .next_ptr, .buf_addr(cmd_addr), .len(cmd_len), .sof(cmd_sof),
    .eof(cmd_eof), .tid(cmd_tid), .tdest(cmd_tdest)
  );

  sgw_engine #(.AW(AW), .LW(LW)) u_eng (
    .clk, .rst_n, .run, .tail_ptr, .tail_pend, .pend_clr, .cur_wr, .cur_wdata,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .cap_en, .cap_idx,
    .next_ptr, .cmd_valid, .cmd_ready, .sts_valid, .sts_bytes,
    .cur_ptr, .halted, .idle, .err
  );

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_len)
      && $stable(cmd_tid) && $stable(cmd_tdest)) else $error("command dropped"); // R11
endmodule

// File: tb/sim_sgw_walker.sv
`timescale 1ns/1ps
module sim_sgw_walker;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] cur_ptr, mem_addr, mem_wdata, mem_rdata, cmd_addr;
  logic        halted, idle, err, mem_req, mem_we, mem_ack, cmd_valid;
  logic        cmd_ready = 1'b0, sts_valid = 1'b0;
  logic [22:0] cmd_len, sts_bytes = '0;
  logic        cmd_sof, cmd_eof;
  logic [4:0]  cmd_tid, cmd_tdest;

  logic [31:0] mem [0:255];
  logic [31:0] lg_addr [0:31];
  logic [22:0] lg_len  [0:31];
  logic [11:0] lg_misc [0:31];
  int ncmd = 0;
  int dm_cd = 0;
  logic [22:0] dm_len = '0;
  int nchk = 0, nfail = 0;
  bit done = 0;

  sgw_walker u0 (.*);

  assign mem_ack   = mem_req;
  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk) if (mem_req && mem_we) mem[mem_addr[9:2]] <= mem_wdata;

  // data mover model: toggling ready, reports one byte short after 3 cycles
  always @(posedge clk) begin
    cmd_ready <= ~cmd_ready;
    sts_valid <= 1'b0;
    if (cmd_valid && cmd_ready) begin
      lg_addr[ncmd[4:0]] <= cmd_addr;
      lg_len[ncmd[4:0]]  <= cmd_len;
      lg_misc[ncmd[4:0]] <= {cmd_sof, cmd_eof, cmd_tid, cmd_tdest};
      ncmd   <= ncmd + 1;
      dm_cd  <= 3;
      dm_len <= cmd_len;
    end else if (dm_cd != 0) begin
      dm_cd <= dm_cd - 1;
      if (dm_cd == 1) begin
        sts_valid <= 1'b1;
        sts_bytes <= dm_len - 23'd1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic wait_flag(input bit want_halt);
    repeat (2) @(negedge clk);
    for (int t = 0; t < 3000; t++) begin
      if (want_halt ? halted : idle) break;
      @(negedge clk);
    end
  endtask

  function automatic logic [22:0] dlen(input int n, input int i);
    return 23'(16 * n + 5 * i + 2);
  endfunction
  function automatic logic [4:0] dtid(input int n, input int i);
    return 5'((n + i) & 31);
  endfunction
  function automatic logic [4:0] ddst(input int n, input int i);
    return 5'((3 * n + 2 * i + 1) & 31);
  endfunction
  function automatic logic [31:0] dbuf(input int n, input int i);
    return 32'h1000_0000 + 32'(n * 256 + i * 16);
  endfunction

  // slot s at byte address 64*s; descriptor parameters from (n, i)
  task automatic build(input int s, input logic [31:0] nxt, input int n, input int i,
                       input bit sof, input bit eof);
    mem[s*16+0] <= nxt;
    mem[s*16+1] <= dbuf(n, i);
    mem[s*16+4] <= {4'd0, sof, eof, 3'd0, dlen(n, i)};
    mem[s*16+5] <= 32'd0;
    mem[s*16+6] <= {19'd0, ddst(n, i), 3'd0, dtid(n, i)};
    @(negedge clk);
  endtask

  task automatic check_cmd(input int idx, input int n, input int i, input bit sof, input bit eof);
    chk("R2 addr", lg_addr[idx], dbuf(n, i));
    chk("R2 len", 32'(lg_len[idx]), 32'(dlen(n, i)));
    chk("R2 sof/eof", 32'(lg_misc[idx][11:10]), 32'({sof, eof}));
    chk("R3 tid/tdest", 32'(lg_misc[idx][9:0]), 32'({dtid(n, i), ddst(n, i)}));
  endtask

  task automatic reset_dut();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 halted", 32'(halted), 1);
    chk("R10 idle", 32'(idle), 0);
    chk("R10 err", 32'(err), 0);
    chk("R10 quiet", 32'({mem_req, cmd_valid}), 0);
    chk("R10 cur", cur_ptr, 0);
  endtask

  initial begin
    for (int a = 0; a < 256; a++) mem[a] <= 32'd0;
    reset_dut();

    // chain-length sweep
    for (int n = 1; n <= 4; n++) begin
      int base;
      base = ncmd;
      for (int i = 0; i < n; i++)
        build(1 + i, 32'(64 * (2 + i)), n, i, i == 0, i == n - 1);
      reg_wr(2'd1, 32'd64);
      if (n % 2 == 0) begin               // R1: run first, tail last
        reg_wr(2'd0, 32'd1);
        wait_flag(1'b0);
        chk("R1 no start before tail", 32'(ncmd - base), 0);
        reg_wr(2'd2, 32'(64 * n));
      end else begin                       // R1: tail first, run last
        reg_wr(2'd2, 32'(64 * n));
        reg_wr(2'd0, 32'd1);
      end
      wait_flag(1'b0);
      chk("R11 one command per descriptor", 32'(ncmd - base), 32'(n));
      for (int i = 0; i < n; i++) begin
        check_cmd(base + i, n, i, i == 0, i == n - 1);
        chk("R4 status", mem[(1 + i) * 16 + 5], 32'h8000_0000 | 32'(dlen(n, i) - 23'd1));
      end
      chk("R5 stop past tail untouched", mem[(1 + n) * 16 + 5], 0);
      chk("R5 cur after tail", cur_ptr, 32'(64 * (n + 1)));
      chk("R5 idle", 32'(idle), 1);
      if (n < 4) begin
        reg_wr(2'd0, 32'd0);
        wait_flag(1'b1);
        chk("R7 halted when stopped idle", 32'(halted), 1);
      end
    end

    // R9: pointer write while running is ignored
    reg_wr(2'd1, 32'd576);
    chk("R9 cur ignored", cur_ptr, 32'd320);

    // R6: tail rewrite on an idle walker
    begin
      int base;
      base = ncmd;
      build(5, 32'd384, 7, 0, 1'b1, 1'b1);
      reg_wr(2'd2, 32'd320);
      wait_flag(1'b0);
      chk("R6 restart count", 32'(ncmd - base), 1);
      check_cmd(base, 7, 0, 1'b1, 1'b1);
      chk("R6 status", mem[5 * 16 + 5], 32'h8000_0000 | 32'(dlen(7, 0) - 23'd1));
      chk("R6 cur", cur_ptr, 32'd384);
    end

    // R7: stop while a transfer is in flight
    reg_wr(2'd0, 32'd0);
    wait_flag(1'b1);
    begin
      int base;
      base = ncmd;
      for (int i = 0; i < 3; i++) build(1 + i, 32'(64 * (2 + i)), 9, i, i == 0, i == 2);
      reg_wr(2'd1, 32'd64);
      chk("R9 cur taken when halted", cur_ptr, 32'd64);
      reg_wr(2'd2, 32'd192);
      reg_wr(2'd0, 32'd1);
      for (int t = 0; t < 2000 && ncmd == base; t++) @(negedge clk);
      reg_wr(2'd0, 32'd0);
      wait_flag(1'b1);
      repeat (10) @(negedge clk);
      chk("R7 one descriptor", 32'(ncmd - base), 1);
      chk("R7 finished status", mem[1 * 16 + 5], 32'h8000_0000 | 32'(dlen(9, 0) - 23'd1));
      chk("R7 next untouched", mem[2 * 16 + 5], 0);
      chk("R7 cur", cur_ptr, 32'd128);
      chk("R7 halted", 32'({halted, idle}), 32'b10);
    end

    // R8: misaligned pointer from software
    begin
      int base;
      base = ncmd;
      reg_wr(2'd1, 32'h104);
      reg_wr(2'd2, 32'h104);
      reg_wr(2'd0, 32'd1);
      repeat (6) @(negedge clk);
      chk("R8 err", 32'({err, halted}), 32'b11);
      chk("R8 no command", 32'(ncmd - base), 0);
      chk("R8 quiet", 32'({mem_req, cmd_valid}), 0);
    end

    // R8: misaligned pointer reached through a chain link
    reset_dut();
    begin
      int base;
      base = ncmd;
      build(1, 32'h90, 11, 0, 1'b1, 1'b0);
      reg_wr(2'd1, 32'd64);
      reg_wr(2'd2, 32'h90);
      reg_wr(2'd0, 32'd1);
      wait_flag(1'b1);
      repeat (4) @(negedge clk);
      chk("R8 chain err", 32'({err, halted}), 32'b11);
      chk("R8 chain one command", 32'(ncmd - base), 1);
      chk("R8 chain cur", cur_ptr, 32'h90);
    end

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule